// File: doc/BRIEF.md
# Multi-Mode Lookup Table Cell

This block is a single storage cell of sixteen bits that can be used in three ways depending on a two-bit mode input. As a truth table it turns four select lines into any Boolean function of four variables: the select lines pick one of the sixteen stored bits and that bit appears on the output with no clock involved. As a small memory the same sixteen bits become a 16x1 RAM. User logic writes one bit on a clock edge and reads any bit asynchronously. As a shift register the bits form a sixteen-stage serial chain. The select lines then choose a tap, which gives a delay line whose length can be set from 1 to 16 cycles.

A preload port writes all sixteen bits at once in any mode and takes priority over the write and shift paths. This is how a truth table is loaded or a RAM or chain is initialised. Internally a small control module turns the mode and enable inputs into a set of mutually exclusive strobes. A datapath module holds the storage, applies those strobes and reads the stored bits through a binary multiplexer tree.

Top module: `lutc_cell`

## Requirements
- R1: While `rstN` is low all sixteen stored bits are cleared, so `dataOut` and `serOut` read 0 for every address.
- R2: When `loadEn` is high at a rising clock edge, all sixteen bits take `loadData` (bit i of `loadData` goes to address i) in any mode. A simultaneous write or shift request is ignored in that cycle.
- R3: In logic mode (`modeSel` = 2'b00), `dataOut` equals the stored bit whose index is the value on `addr`, combinationally.
- R4: In logic mode and in the reserved mode (`modeSel` = 2'b11), `wrEn` and `shEn` have no effect on the stored bits. Only the preload changes them.
- R5: In RAM mode (`modeSel` = 2'b01), when `wrEn` is high at a rising edge the bit at `addr` takes `wrData`, and no other bit changes.
- R6: In RAM mode the read is asynchronous. While a write to the addressed bit is pending, `dataOut` still shows the old value until the clock edge.
- R7: In shift mode (`modeSel` = 2'b10), when `shEn` is high at a rising edge, bit 0 takes `serIn` and bit k takes the old bit k-1. `serOut` always shows bit 15.
- R8: In shift mode `dataOut` is the tap at index `addr`, so a value shifted in appears there after exactly `addr`+1 enabled shifts.
- R9: In shift mode `wrEn` is ignored, and in RAM mode `shEn` is ignored.
- R10: In shift mode, with `shEn` low and no preload, the stored bits hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset, clears storage |
| modeSel | input | 2 | 00 logic, 01 RAM, 10 shift, 11 reserved (acts as logic) |
| addr | input | 4 | Select lines: truth-table input, RAM address or shift tap |
| loadEn | input | 1 | Preload strobe for all sixteen bits |
| loadData | input | 16 | Preload value, bit i to address i |
| wrEn | input | 1 | RAM write enable |
| wrData | input | 1 | RAM write data |
| shEn | input | 1 | Shift enable |
| serIn | input | 1 | Serial input into bit 0 |
| dataOut | output | 1 | Stored bit selected by `addr` |
| serOut | output | 1 | Serial output, bit 15 |

## Verification
On every cycle the assertions check the following:
- the strobes never overlap;
- logic and reserved modes never raise a write or shift strobe;
- a preload, write or shift produces exactly the expected next storage contents;
- storage stays stable when no strobe is active.

Other behaviours can only be shown by the bench scenarios. These are the combinational read through the multiplexer tree for every address, the old-value read during a pending RAM write, the exact tap delay of `addr`+1 shifts at several tap positions, and the reset contents seen at the ports.

// File: rtl/lutc_pkg.sv
package lutc_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_RAM   = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef struct packed {
    logic load;
    logic write;
    logic shift;
  } strobe_t;

endpackage

// File: rtl/lutc_ctrl.sv
module lutc_ctrl
  import lutc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       loadEn,
  input  logic       wrEn,
  input  logic       shEn,
  output strobe_t    stb
);

  mode_e mode;

  always_comb begin
    mode      = mode_e'(modeSel);
    stb.load  = loadEn;
    stb.write = !loadEn && (mode == MODE_RAM) && wrEn;
    stb.shift = !loadEn && (mode == MODE_SHIFT) && shEn;
  end

  // R2: preload wins, strobes never overlap
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.write, stb.shift}));

  // R4: logic and reserved modes never modify storage except through preload
  a_r4_logic_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 || modeSel == 2'b11) |-> (!stb.write && !stb.shift));

  // R9: cross-mode enables ignored
  a_r9_cross_mode: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == 2'b01) |-> !stb.shift) and ((modeSel == 2'b10) |-> !stb.write));

endmodule

// File: rtl/lutc_store.sv
module lutc_store
  import lutc_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int NODES = 2 * DEPTH - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DEPTH-1:0]  loadData,
  input  logic              wrData,
  input  logic              serIn,
  output logic              dataOut,
  output logic              serOut
);

  logic [DEPTH-1:0] cells;
  logic [NODES-1:0] node;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cells <= '0;
    else if (stb.load)  cells <= loadData;
    else if (stb.write) cells[addr] <= wrData;
    else if (stb.shift) cells <= {cells[DEPTH-2:0], serIn};
  end

  // Binary select tree: leaves hold the cells, root is the output.
  // Level d chooses with addr bit ADDR_W-1-d (MSB at the root).
  assign node[NODES-1:DEPTH-1] = cells;

  for (genvar d = 0; d < ADDR_W; d++) begin : g_level
    for (genvar k = 0; k < (1 << d); k++) begin : g_node
      localparam int J = (1 << d) - 1 + k;
      assign node[J] = addr[ADDR_W-1-d] ? node[2*J+2] : node[2*J+1];
    end
  end

  assign dataOut = node[0];
  assign serOut  = cells[DEPTH-1];

  // R2: preload replaces all bits
  a_r2_preload: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && $past(rstN)) |=> (cells == $past(loadData)));

  // R5: single-bit write hits only the addressed bit
  a_r5_write_bit: assert property (@(posedge clk) disable iff (!rstN)
    (stb.write && $past(rstN)) |=>
      ((cells ^ $past(cells)) & ~(DEPTH'(1) << $past(addr))) == '0 &&
      cells[$past(addr)] == $past(wrData));

  // R7: shift moves every bit up one place
  a_r7_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && $past(rstN)) |=>
      (cells == {$past(cells[DEPTH-2:0]), $past(serIn)}));

  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.write && !stb.shift && $past(rstN)) |=> $stable(cells));

endmodule

// File: rtl/lutc_cell.sv
module lutc_cell
  import lutc_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              loadEn,
  input  logic [DEPTH-1:0]  loadData,
  input  logic              wrEn,
  input  logic              wrData,
  input  logic              shEn,
  input  logic              serIn,
  output logic              dataOut,
  output logic              serOut
);

  strobe_t stb;

  lutc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .loadEn  (loadEn),
    .wrEn    (wrEn),
    .shEn    (shEn),
    .stb     (stb)
  );

  lutc_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addr     (addr),
    .loadData (loadData),
    .wrData   (wrData),
    .serIn    (serIn),
    .dataOut  (dataOut),
    .serOut   (serOut)
  );

endmodule

// File: tb/tb_lutc_cell.sv
`timescale 1ns/100ps
module tb_lutc_cell;

  logic        clk = 0;
  logic        rstN = 0;
  logic [1:0]  modeSel = 2'b00;
  logic [3:0]  addr = 0;
  logic        loadEn = 0;
  logic [15:0] loadData = 0;
  logic        wrEn = 0, wrData = 0, shEn = 0, serIn = 0;
  logic        dataOut, serOut;

  int nChk = 0, nErr = 0;
  logic [15:0] m = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lutc_cell dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .addr(addr),
    .loadEn(loadEn), .loadData(loadData), .wrEn(wrEn), .wrData(wrData),
    .shEn(shEn), .serIn(serIn), .dataOut(dataOut), .serOut(serOut)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic readAll(input string tag);
    logic [3:0] keep = addr;
    logic [15:0] got;
    for (int a = 0; a < 16; a++) begin
      addr = a[3:0]; #0.1;
      got[a] = dataOut;
    end
    addr = keep;
    nChk++;
    if (got !== m) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, m);
    end
  endtask

  task automatic preload(input logic [15:0] v);
    loadData = v; loadEn = 1; cyc(); loadEn = 0; m = v;
  endtask

  task automatic t_reset();
    rstN = 0; #5;
    addr = 0;  #0.1; chk("R1 reset addr0", dataOut, 1'b0);
    addr = 15; #0.1; chk("R1 reset addr15", dataOut, 1'b0);
    chk("R1 reset serOut", serOut, 1'b0);
    cyc(); rstN = 1; cyc();
    m = 0; readAll("R1 all zero after reset");
  endtask

  task automatic t_logic();
    modeSel = 2'b00;
    preload(16'hA5C3);
    for (int a = 0; a < 16; a++) begin
      addr = a[3:0]; #0.1;
      chk($sformatf("R3 logic addr %0d", a), dataOut, m[a]);
    end
    preload(16'h6996);
    readAll("R2 preload xor4 table");
    wrEn = 1; wrData = 1; shEn = 1; serIn = 1; addr = 0;
    cyc(); cyc();
    wrEn = 0; shEn = 0;
    readAll("R4 logic mode ignores write/shift");
    modeSel = 2'b11; wrEn = 1; shEn = 1; cyc(); wrEn = 0; shEn = 0;
    readAll("R4 reserved mode ignores write/shift");
  endtask

  task automatic t_ram();
    modeSel = 2'b01;
    preload(16'h0F0F);
    addr = 5; wrData = ~m[5]; wrEn = 1; #0.1;
    chk("R6 old value before edge", dataOut, m[5]);
    cyc(); wrEn = 0; m[5] = wrData; #0.1;
    chk("R5 new value after edge", dataOut, m[5]);
    readAll("R5 only addressed bit changed");
    for (int a = 12; a < 16; a++) begin
      addr = a[3:0]; wrData = a[0]; wrEn = 1; cyc(); m[a] = a[0];
    end
    wrEn = 0;
    readAll("R5 several writes");
    shEn = 1; serIn = 1; cyc(); shEn = 0;
    readAll("R9 RAM mode ignores shEn");
    addr = 2; wrData = 1; wrEn = 1; loadData = 16'h8001; loadEn = 1;
    cyc(); wrEn = 0; loadEn = 0; m = 16'h8001;
    readAll("R2 preload beats write");
  endtask

  task automatic t_shift();
    logic [15:0] pat = 16'b1011_0010_1110_0101;
    modeSel = 2'b10;
    preload(16'h0000);
    for (int n = 0; n < 16; n++) begin
      serIn = pat[n]; shEn = 1; cyc();
      m = {m[14:0], pat[n]}; #0.1;
      chk($sformatf("R7 serOut step %0d", n), serOut, m[15]);
    end
    shEn = 0;
    readAll("R7 shifted contents");
    cyc(); cyc();
    readAll("R10 hold with shEn low");
    addr = 3; wrEn = 1; wrData = ~m[3]; cyc(); wrEn = 0;
    readAll("R9 shift mode ignores wrEn");
    serIn = 0; shEn = 1; loadData = 16'hFFFF; loadEn = 1; cyc();
    shEn = 0; loadEn = 0; m = 16'hFFFF;
    readAll("R2 preload beats shift");
    foreach (pat[i]) ;
    for (int t = 0; t < 3; t++) begin
      int k = (t == 0) ? 0 : (t == 1) ? 6 : 15;
      preload(16'h0000);
      addr = k[3:0];
      for (int n = 1; n <= k + 1; n++) begin
        serIn = (n == 1); shEn = 1; cyc(); #0.1;
        chk($sformatf("R8 tap %0d after %0d shifts", k, n), dataOut, (n == k + 1));
      end
      shEn = 0;
      if (k == 15) chk("R7 serOut after 16 shifts", serOut, 1'b1);
    end
  endtask

  initial begin
    t_reset();
    t_logic();
    t_ram();
    t_shift();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nErr++; nChk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

endmodule